// File: doc/BRIEF.md
# Vector Lane Mask Register Bank

This block holds the predicate state of an 8-lane vector unit. It has eight 8-bit mask registers, with one bit for each lane. Register 0 also drives the lane-enable vector that masked vector instructions use. The bank carries out mask-to-mask logic (AND, OR, XOR, NOT). It can load one mask from the low bits of a scalar operand or from an immediate. It also moves the whole bank to or from one 64-bit scalar word, and it counts the set or clear bits of a mask into a zero-extended scalar result.

Operations come in already decoded. The inputs are an operation code, three register indices, a 64-bit scalar operand and an 8-bit immediate. Results that go to the scalar side are registered and appear one cycle after issue, marked by a valid pulse. Vector compares write their mask results through a separate write port. When that port and an operation write the same register in the same cycle, the operation wins. No operation reads out a single mask. Software reads masks through the bulk read or through the population counts.

Top module: `vmask_bank`

## Requirements
- R1: While reset is held and immediately after it is released, registers 1..7 are 0, register 0 is 8'hFF, `res_data` is 0 and `res_valid` is 0.
- R2: Op codes 1 (AND), 2 (OR) and 3 (XOR) write `rs1 op rs2` into register `rd`. The new value is visible in the cycle after issue, and the operands are the values held before that edge.
- R3: Op code 4 writes the bitwise inverse of register `rs1` into register `rd`.
- R4: Op code 5 loads register `rd` from `scalar_in[7:0]`, and the upper scalar bits are ignored. Op code 6 loads register `rd` from `imm_in`.
- R5: Op code 7 puts the whole bank on `res_data` in the next cycle, with register k at bits [8k+7:8k], and pulses `res_valid`.
- R6: Op code 8 writes every register k from `scalar_in[8k+7:8k]` in one cycle.
- R7: Op code 9 returns the number of 1 bits of register `rs1`, zero-extended to 64 bits, on `res_data` one cycle later with `res_valid` high.
- R8: Op code 10 returns the number of 0 bits of register `rs1`, zero-extended, with the same timing as R7.
- R9: `lane_en` always equals the current content of register 0.
- R10: When `cmp_we` is high, `cmp_mask` is written into register `cmp_idx`. If an operation writes the same register in that cycle (this includes op code 8), the operation's value is kept. Writes to different registers in the same cycle both take effect.
- R11: When `op_valid` is low, or the op code is 0 or 11..15, no register changes, `res_data` holds its value and `res_valid` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation issue strobe |
| op_code | input | 4 | Operation select (see requirements) |
| rd_idx | input | 3 | Destination mask register |
| rs1_idx | input | 3 | First source mask register |
| rs2_idx | input | 3 | Second source mask register |
| scalar_in | input | 64 | Scalar operand |
| imm_in | input | 8 | Immediate mask value |
| cmp_we | input | 1 | Compare write enable |
| cmp_idx | input | 3 | Compare destination register |
| cmp_mask | input | 8 | Compare result mask |
| res_data | output | 64 | Scalar result |
| res_valid | output | 1 | Scalar result valid pulse |
| lane_en | output | 8 | Lane enables (register 0) |

## Verification
All 256 immediate values are loaded in turn across the registers and counted both ways. This tells a wrong ones-count apart from a wrong zeros-count, and it exposes any mis-weighted bit. The logic ops are swept over every pair of source registers, including the cases where both sources are the same register and where the destination is also a source. Those cases separate reading before the write from reading after it. Bulk writes with byte patterns that are all different catch swapped or shifted slices. Directed cycles drive the compare port alone, alongside an operation to the same register and to a different register, and alongside a bulk write, to pin down the write priority.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
    localparam int NUM_MASKS = 8;
    localparam int LANES     = 8;
    localparam int XLEN      = 64;

    typedef enum logic [3:0] {
        MOP_NONE   = 4'd0,
        MOP_AND    = 4'd1,
        MOP_OR     = 4'd2,
        MOP_XOR    = 4'd3,
        MOP_NOT    = 4'd4,
        MOP_LDX    = 4'd5,
        MOP_LDI    = 4'd6,
        MOP_RDALL  = 4'd7,
        MOP_WRALL  = 4'd8,
        MOP_CNT1   = 4'd9,
        MOP_CNT0   = 4'd10
    } mop_e;
endpackage

// File: rtl/vmask_bitop.sv
module vmask_bitop
    import vmask_pkg::*;
#(
    parameter int LANES_P = LANES
) (
    input  mop_e               op,
    input  logic [LANES_P-1:0] a,
    input  logic [LANES_P-1:0] b,
    output logic [LANES_P-1:0] y
);
    always_comb begin
        case (op)
            MOP_AND: y = a & b;
            MOP_OR:  y = a | b;
            MOP_XOR: y = a ^ b;
            default: y = ~a;
        endcase
    end
endmodule

// File: rtl/vmask_popcnt.sv
module vmask_popcnt #(
    parameter int LANES_P = 8,
    parameter int XLEN_P  = 64
) (
    input  logic [LANES_P-1:0] mask,
    input  logic               count_zeros,
    output logic [XLEN_P-1:0]  count
);
    localparam int CW = $clog2(LANES_P + 1);

    logic [LANES_P-1:0] src;
    logic [CW-1:0]      acc;

    always_comb begin
        src = count_zeros ? ~mask : mask;
        acc = '0;
        for (int i = 0; i < LANES_P; i++) begin
            acc = acc + CW'(src[i]);
        end
        count = XLEN_P'(acc);
    end
endmodule

// File: rtl/vmask_pack.sv
module vmask_pack #(
    parameter int NUM_MASKS_P = 8,
    parameter int LANES_P     = 8,
    parameter int XLEN_P      = 64
) (
    input  logic [NUM_MASKS_P*LANES_P-1:0] bank,
    output logic [XLEN_P-1:0]              word
);
    localparam int TOTAL = NUM_MASKS_P * LANES_P;

    generate
        if (TOTAL == XLEN_P) begin : g_exact
            assign word = bank;
        end else begin : g_pad
            assign word = {{(XLEN_P - TOTAL){1'b0}}, bank};
        end
    endgenerate
endmodule

// File: rtl/vmask_bank.sv
module vmask_bank
    import vmask_pkg::*;
#(
    parameter int NUM_MASKS_P = NUM_MASKS,
    parameter int LANES_P     = LANES,
    parameter int XLEN_P      = XLEN,
    localparam int IDX_W      = $clog2(NUM_MASKS_P)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [3:0]         op_code,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [IDX_W-1:0]   rs1_idx,
    input  logic [IDX_W-1:0]   rs2_idx,
    input  logic [XLEN_P-1:0]  scalar_in,
    input  logic [LANES_P-1:0] imm_in,
    input  logic               cmp_we,
    input  logic [IDX_W-1:0]   cmp_idx,
    input  logic [LANES_P-1:0] cmp_mask,
    output logic [XLEN_P-1:0]  res_data,
    output logic               res_valid,
    output logic [LANES_P-1:0] lane_en
);
    typedef struct packed {
        logic [NUM_MASKS_P-1:0][LANES_P-1:0] m;
        logic [XLEN_P-1:0]                   res;
        logic                                vld;
    } state_t;

    state_t state_d, state_q;
    mop_e   op;

    logic [LANES_P-1:0] src_a, src_b, logic_y;
    logic [XLEN_P-1:0]  cnt_word, bank_word;

    assign op    = mop_e'(op_code);
    assign src_a = state_q.m[rs1_idx];
    assign src_b = state_q.m[rs2_idx];

    vmask_bitop #(.LANES_P(LANES_P)) u_bitop (
        .op (op),
        .a  (src_a),
        .b  (src_b),
        .y  (logic_y)
    );

    vmask_popcnt #(.LANES_P(LANES_P), .XLEN_P(XLEN_P)) u_popcnt (
        .mask        (src_a),
        .count_zeros (op == MOP_CNT0),
        .count       (cnt_word)
    );

    vmask_pack #(.NUM_MASKS_P(NUM_MASKS_P), .LANES_P(LANES_P), .XLEN_P(XLEN_P)) u_pack (
        .bank (state_q.m),
        .word (bank_word)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = 1'b0;
        // compare port first: an operation write below overrides it
        if (cmp_we) begin
            state_d.m[cmp_idx] = cmp_mask;
        end
        if (op_valid) begin
            case (op)
                MOP_AND, MOP_OR, MOP_XOR, MOP_NOT: state_d.m[rd_idx] = logic_y;
                MOP_LDX: state_d.m[rd_idx] = scalar_in[LANES_P-1:0];
                MOP_LDI: state_d.m[rd_idx] = imm_in;
                MOP_RDALL: begin
                    state_d.res = bank_word;
                    state_d.vld = 1'b1;
                end
                MOP_WRALL: begin
                    for (int k = 0; k < NUM_MASKS_P; k++) begin
                        state_d.m[k] = scalar_in[k*LANES_P +: LANES_P];
                    end
                end
                MOP_CNT1, MOP_CNT0: begin
                    state_d.res = cnt_word;
                    state_d.vld = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.m[0] <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_data  = state_q.res;
    assign res_valid = state_q.vld;
    assign lane_en   = state_q.m[0];
endmodule

// File: rtl/vmask_bank_chk.sv
module vmask_bank_chk
    import vmask_pkg::*;
#(
    parameter int LANES_P = 8,
    parameter int XLEN_P  = 64,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid,
    input logic [3:0]         op_code,
    input logic [IDX_W-1:0]   rd_idx,
    input logic [IDX_W-1:0]   rs1_idx,
    input logic [LANES_P-1:0] imm_in,
    input logic               cmp_we,
    input logic [IDX_W-1:0]   cmp_idx,
    input logic [LANES_P-1:0] cmp_mask,
    input logic [XLEN_P-1:0]  res_data,
    input logic               res_valid,
    input logic [LANES_P-1:0] lane_en
);
    p_cnt_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == MOP_CNT1 && rs1_idx == '0
        |=> res_valid && res_data == XLEN_P'($countones($past(lane_en))));

    p_cnt_zeros_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == MOP_CNT0 && rs1_idx == '0
        |=> res_valid && res_data == XLEN_P'(LANES_P - $countones($past(lane_en))));

    p_invert_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == MOP_NOT && rd_idx == '0 && rs1_idx == '0
        |=> lane_en == ~$past(lane_en));

    p_imm_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == MOP_LDI && rd_idx == '0
        |=> lane_en == $past(imm_in));

    p_cmp_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid && cmp_we && cmp_idx == '0
        |=> lane_en == $past(cmp_mask));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid && !cmp_we
        |=> $stable(lane_en) && $stable(res_data) && !res_valid);

    p_rdall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == MOP_RDALL
        |=> res_valid && res_data[LANES_P-1:0] == $past(lane_en));
endmodule

bind vmask_bank vmask_bank_chk #(
    .LANES_P (LANES_P),
    .XLEN_P  (XLEN_P),
    .IDX_W   (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .rd_idx    (rd_idx),
    .rs1_idx   (rs1_idx),
    .imm_in    (imm_in),
    .cmp_we    (cmp_we),
    .cmp_idx   (cmp_idx),
    .cmp_mask  (cmp_mask),
    .res_data  (res_data),
    .res_valid (res_valid),
    .lane_en   (lane_en)
);

// File: tb/vmask_bank_tb.sv
module vmask_bank_tb;
    localparam logic [3:0] C_NONE = 4'd0, C_AND = 4'd1, C_OR = 4'd2, C_XOR = 4'd3,
                           C_NOT = 4'd4, C_LDX = 4'd5, C_LDI = 4'd6, C_RDALL = 4'd7,
                           C_WRALL = 4'd8, C_CNT1 = 4'd9, C_CNT0 = 4'd10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [2:0]  rd_idx = '0, rs1_idx = '0, rs2_idx = '0, cmp_idx = '0;
    logic [63:0] scalar_in = '0;
    logic [7:0]  imm_in = '0, cmp_mask = '0;
    logic        cmp_we = 1'b0;
    logic [63:0] res_data;
    logic        res_valid;
    logic [7:0]  lane_en;

    logic [7:0]  exp_m [8];
    logic [63:0] exp_res;
    logic        exp_vld;
    int          n_cmp = 0, n_bad = 0;

    always #5 clk = ~clk;

    vmask_bank u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
        .scalar_in(scalar_in), .imm_in(imm_in), .cmp_we(cmp_we),
        .cmp_idx(cmp_idx), .cmp_mask(cmp_mask), .res_data(res_data),
        .res_valid(res_valid), .lane_en(lane_en)
    );

    function automatic int ones8(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic [63:0] bank_model();
        logic [63:0] w = '0;
        for (int k = 0; k < 8; k++) w = w + (64'(exp_m[k]) << (8 * k));
        return w;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag);
        chk({tag, " lane_en R9"}, 64'(lane_en), 64'(exp_m[0]));
        chk({tag, " res_data"}, res_data, exp_res);
        chk({tag, " res_valid"}, 64'(res_valid), 64'(exp_vld));
    endtask

    // drive at a falling edge, model the effect, return at the next falling edge
    task automatic go(input logic v, input logic [3:0] c, input logic [2:0] rd,
                      input logic [2:0] a, input logic [2:0] b, input logic [63:0] sc,
                      input logic [7:0] im, input logic cwe, input logic [2:0] ci,
                      input logic [7:0] cm);
        logic [7:0] va, vb;
        op_valid = v; op_code = c; rd_idx = rd; rs1_idx = a; rs2_idx = b;
        scalar_in = sc; imm_in = im; cmp_we = cwe; cmp_idx = ci; cmp_mask = cm;
        va = exp_m[a];
        vb = exp_m[b];
        exp_vld = 1'b0;
        if (v && c == C_RDALL) begin exp_res = bank_model(); exp_vld = 1'b1; end
        if (v && c == C_CNT1)  begin exp_res = 64'(ones8(va)); exp_vld = 1'b1; end
        if (v && c == C_CNT0)  begin exp_res = 64'(8 - ones8(va)); exp_vld = 1'b1; end
        if (cwe) exp_m[ci] = cm;
        if (v) begin
            case (c)
                C_AND: exp_m[rd] = va & vb;
                C_OR:  exp_m[rd] = va | vb;
                C_XOR: exp_m[rd] = va ^ vb;
                C_NOT: exp_m[rd] = ~va;
                C_LDX: exp_m[rd] = sc[7:0];
                C_LDI: exp_m[rd] = im;
                C_WRALL: for (int k = 0; k < 8; k++) exp_m[k] = sc[8*k +: 8];
                default: ;
            endcase
        end
        @(negedge clk);
        op_valid = 1'b0;
        cmp_we   = 1'b0;
    endtask

    task automatic op(input logic [3:0] c, input logic [2:0] rd, input logic [2:0] a,
                      input logic [2:0] b, input logic [63:0] sc, input logic [7:0] im);
        go(1'b1, c, rd, a, b, sc, im, 1'b0, 3'd0, 8'd0);
    endtask

    task automatic read_bank(input string tag);
        op(C_RDALL, 3'd0, 3'd0, 3'd0, 64'd0, 8'd0);
        chk({tag, " bulk read R5"}, res_data, bank_model());
        chk({tag, " bulk valid R5"}, 64'(res_valid), 64'd1);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) exp_m[k] = (k == 0) ? 8'hFF : 8'h00;
        exp_res = '0;
        exp_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk_out("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_out("R1 after reset");
        read_bank("R1 reset bank");

        // R4 R7 R8: every immediate, counted both ways
        for (int v = 0; v < 256; v++) begin
            op(C_LDI, 3'(v), 3'd0, 3'd0, 64'd0, 8'(v));
            chk_out("R4 ldi");
            op(C_CNT1, 3'd0, 3'(v), 3'd0, 64'd0, 8'd0);
            chk_out("R7 count ones");
            op(C_CNT0, 3'd0, 3'(v), 3'd0, 64'd0, 8'd0);
            chk_out("R8 count zeros");
        end
        read_bank("R4 after ldi sweep");

        // R4: scalar load uses only the low byte
        for (int k = 0; k < 8; k++) begin
            op(C_LDX, 3'(k), 3'd0, 3'd0, {56'hA5C3_F00F_1234_56, 8'(k * 37 + 3)}, 8'd0);
            chk_out("R4 ldx");
        end
        read_bank("R4 ldx bank");

        // R6 R5: bulk write with distinct bytes, read back
        for (int p = 0; p < 6; p++) begin
            op(C_WRALL, 3'd0, 3'd0, 3'd0,
               64'h0123_4567_89AB_CDEF ^ (64'h1111_1111_1111_1111 * 64'(p)) ^ 64'(p << 3),
               8'd0);
            chk_out("R6 bulk write");
            read_bank("R6 bulk round trip");
        end

        // R2 R3: every source pair, destination rotating over sources too
        for (int c = 1; c <= 4; c++) begin
            op(C_WRALL, 3'd0, 3'd0, 3'd0, 64'h3C5A_96F0_0FE1_7B82 + 64'(c * 977), 8'd0);
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    op(4'(c), 3'(i + j + c), 3'(i), 3'(j), 64'd0, 8'd0);
                    chk_out(c == 4 ? "R3 not" : "R2 logic");
                end
                read_bank(c == 4 ? "R3 bank" : "R2 bank");
            end
        end

        // R10: compare port alone, colliding, disjoint, and against bulk write
        go(1'b0, C_NONE, 3'd0, 3'd0, 3'd0, 64'd0, 8'd0, 1'b1, 3'd3, 8'h6E);
        read_bank("R10 compare alone");
        go(1'b0, C_NONE, 3'd0, 3'd0, 3'd0, 64'd0, 8'd0, 1'b1, 3'd0, 8'h81);
        chk_out("R10 compare to lane register");
        go(1'b1, C_LDI, 3'd0, 3'd0, 3'd0, 64'd0, 8'h5A, 1'b1, 3'd0, 8'hA5);
        chk_out("R10 op wins same register");
        go(1'b1, C_LDI, 3'd1, 3'd0, 3'd0, 64'd0, 8'h77, 1'b1, 3'd2, 8'h19);
        read_bank("R10 disjoint writes");
        go(1'b1, C_WRALL, 3'd0, 3'd0, 3'd0, 64'hF1E2_D3C4_B5A6_9788, 8'd0, 1'b1, 3'd5, 8'h00);
        read_bank("R10 bulk write wins");
        go(1'b1, C_NOT, 3'd4, 3'd4, 3'd0, 64'd0, 8'd0, 1'b1, 3'd4, 8'h0F);
        read_bank("R10 not wins");

        // R11: held ops and unused codes change nothing
        op(C_CNT1, 3'd0, 3'd6, 3'd0, 64'd0, 8'd0);
        chk_out("R11 setup");
        go(1'b0, C_LDI, 3'd0, 3'd0, 3'd0, 64'hFFFF, 8'h00, 1'b0, 3'd0, 8'd0);
        chk_out("R11 op_valid low");
        go(1'b0, C_WRALL, 3'd0, 3'd0, 3'd0, 64'd0, 8'd0, 1'b0, 3'd0, 8'd0);
        chk_out("R11 op_valid low bulk");
        for (int c = 11; c < 16; c++) begin
            op(4'(c), 3'(c), 3'd1, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
            chk_out("R11 unused code");
        end
        op(C_NONE, 3'd0, 3'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
        chk_out("R11 code zero");
        read_bank("R11 bank intact");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule